// File: doc/BRIEF.md
# LFSR Fetch Sequencer with Call/Return Stack

This block produces the instruction fetch address for a small soft processor that issues one instruction per clock on a single-phase clock. The sequential fetch order is not a binary count. The 10-bit program counter advances by one step of a maximal-length linear feedback shift register. This removes the carry chain from the next-address path. The assembler is expected to place code in that same order.

Decoded control from the instruction stage steers the next address. Three controls can do this:
- A jump loads a target address.
- A call loads the target and, in the same cycle, saves the sequential successor of the current address on a dedicated 16-deep return stack.
- A return takes the top stack entry as the next address in the same cycle as the instruction that carries it, so it costs no extra cycles.

The top of the stack is always visible on the return-address output.

Top module: `lfsr_fetch_seq`

## Requirements
- R1: During and after synchronous active-low reset, `fetch_addr` is 10'h001, the stack pointer is zero and all stack entries are zero, so `ret_addr` reads 0.
- R2: With no control asserted, the next `fetch_addr` is `{pc[8:0], pc[9] ^ pc[6]}` (polynomial x^10 + x^7 + 1).
- R3: Stepping only sequentially from a nonzero address, the address never becomes zero and first returns to its start after exactly 1023 clocks.
- R4: With `jump_en` high, the next `fetch_addr` equals `target_addr` and the stack (pointer and `ret_addr`) is unchanged.
- R5: With `call_en` high and `jump_en` low, the next `fetch_addr` equals `target_addr`, and the R2 successor of the current address is pushed, so the following cycle `ret_addr` shows it.
- R6: With `ret_en` high and the other two low, the next `fetch_addr` equals the current `ret_addr`, and the stack pointer drops by one.
- R7: Priority is jump over call over return. A lower-priority control asserted together with a higher one has no effect on the address or the stack.
- R8: The 4-bit stack pointer wraps silently. A 17th push overwrites the oldest entry, and a pop at depth zero reads entry 15.
- R9: `ret_addr` always shows the entry just below the stack pointer, that is, the most recent unpopped push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| jump_en | input | 1 | Decoded jump: load target |
| call_en | input | 1 | Decoded call: load target, push successor |
| ret_en | input | 1 | Decoded return: pop, fetch from popped entry |
| target_addr | input | 10 | Jump or call destination (nonzero) |
| fetch_addr | output | 10 | Current program counter / fetch address |
| ret_addr | output | 10 | Top entry of the return stack |

## Verification
The bench uses the default parameters: a 10-bit address, tap mask 10'h240, start address 1 and a 16-entry stack. With these values the full 1023-state cycle can be walked in one directed pass. The small stack depth lets random call and return bursts wrap the pointer in both directions many times, so overwrite-on-overflow and read-of-entry-15-on-underflow both occur regularly.

// File: rtl/seq_pkg.sv
// Package: shared types for the LFSR fetch sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package seq_pkg;

    // Source chosen for the next program counter value
    typedef enum logic [1:0] {
        SRC_STEP   = 2'd0,
        SRC_TARGET = 2'd1,
        SRC_STACK  = 2'd2
    } next_src_e;

endpackage

// File: rtl/lfsr_step.sv
// Module: lfsr_step
// Computes one Fibonacci LFSR step, shifting toward the MSB. The new LSB is
// the XOR of the state bits selected by TAP_MASK.
// Assumes: TAP_MASK describes a maximal-length polynomial for W bits, and the
// state is nonzero.
module lfsr_step #(
    parameter int          W        = 10,
    parameter logic [W-1:0] TAP_MASK = 10'h240
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    logic feedback;

    // Parity of the tapped bits forms the incoming bit
    always_comb begin
        feedback = ^(cur & TAP_MASK);
        nxt      = {cur[W-2:0], feedback};
    end

endmodule

// File: rtl/ret_stack.sv
// Module: ret_stack
// Circular return-address stack with a wrapping pointer. A push writes at
// the pointer and advances it. A pop moves the pointer back. The top output
// is the entry just below the pointer. Push wins if both are asserted.
// Assumes: DEPTH is a power of two; all entries clear on reset.
module ret_stack #(
    parameter int W     = 10,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] top_idx;

    // Entry below the pointer is the most recent return address
    always_comb begin
        top_idx = sp - PTR_W'(1);
        top     = mem[top_idx];
    end

    // Pointer update and entry write; pointer wraps silently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push) begin
            mem[sp] <= wdata;
            sp      <= sp + PTR_W'(1);
        end else if (pop) begin
            sp <= sp - PTR_W'(1);
        end
    end

    // R5: a pushed value is the top one cycle later
    assert_push_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top == $past(wdata)));

    // R6: a pop alone lowers the pointer by one (wrapping, R8)
    assert_pop_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (sp == $past(sp) - PTR_W'(1)));

    // R4: without push or pop the top entry stays put
    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !push) |=> $stable(top));

endmodule

// File: rtl/next_pc_sel.sv
// Module: next_pc_sel
// Priority decode of the control inputs (jump over call over return) into
// a next-address source and the stack push/pop strobes, then the mux.
// Assumes: control inputs are already decoded, one cycle per instruction.
module next_pc_sel
    import seq_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         jump_en,
    input  logic         call_en,
    input  logic         ret_en,
    input  logic [W-1:0] target,
    input  logic [W-1:0] seq_next,
    input  logic [W-1:0] stack_top,
    output logic         push,
    output logic         pop,
    output logic [W-1:0] pc_next
);

    next_src_e src;

    // Resolve priority and choose the source
    always_comb begin
        push = 1'b0;
        pop  = 1'b0;
        src  = SRC_STEP;
        if (jump_en) begin
            src = SRC_TARGET;
        end else if (call_en) begin
            src  = SRC_TARGET;
            push = 1'b1;
        end else if (ret_en) begin
            src = SRC_STACK;
            pop = 1'b1;
        end
    end

    // Next-address multiplexer
    always_comb begin
        unique case (src)
            SRC_TARGET: pc_next = target;
            SRC_STACK:  pc_next = stack_top;
            default:    pc_next = seq_next;
        endcase
    end

endmodule

// File: rtl/lfsr_fetch_seq.sv
// Module: lfsr_fetch_seq (top)
// Program counter register for a one-instruction-per-clock core. It steps
// in LFSR order and handles jump, single-cycle call and zero-cycle return
// through a dedicated return stack.
// Assumes: START_ADDR and every target are nonzero; the code image is laid
// out in LFSR order.
module lfsr_fetch_seq #(
    parameter int                ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] TAP_MASK   = 10'h240,
    parameter logic [ADDR_W-1:0] START_ADDR = 10'h001,
    parameter int                STACK_D    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jump_en,
    input  logic              call_en,
    input  logic              ret_en,
    input  logic [ADDR_W-1:0] target_addr,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] ret_addr
);

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] seq_next;
    logic [ADDR_W-1:0] pc_next;
    logic              push;
    logic              pop;

    lfsr_step #(.W(ADDR_W), .TAP_MASK(TAP_MASK)) u_step (
        .cur (pc),
        .nxt (seq_next)
    );

    next_pc_sel #(.W(ADDR_W)) u_sel (
        .jump_en   (jump_en),
        .call_en   (call_en),
        .ret_en    (ret_en),
        .target    (target_addr),
        .seq_next  (seq_next),
        .stack_top (ret_addr),
        .push      (push),
        .pop       (pop),
        .pc_next   (pc_next)
    );

    ret_stack #(.W(ADDR_W), .DEPTH(STACK_D)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (seq_next),
        .top   (ret_addr)
    );

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= START_ADDR;
        else        pc <= pc_next;
    end

    assign fetch_addr = pc;

    // R2: an idle cycle performs exactly one LFSR shift
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_en && !call_en && !ret_en) |=>
            (fetch_addr[ADDR_W-1:1] == $past(fetch_addr[ADDR_W-2:0])));

    // R3: sequential stepping never reaches the all-zero lockup state
    assert_no_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_en && !call_en && !ret_en && fetch_addr != '0) |=>
            (fetch_addr != '0));

    // R4 and R7: jump loads the target regardless of the other controls
    assert_jump_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        jump_en |=> (fetch_addr == $past(target_addr)));

    // R6: a return fetches from the stack top seen in its own cycle
    assert_ret_zero_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !jump_en && !call_en) |=> (fetch_addr == $past(ret_addr)));

endmodule

// File: tb/tb_lfsr_fetch_seq.sv
module tb_lfsr_fetch_seq;

    localparam int AW = 10;
    localparam int SD = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          jump_en = 1'b0;
    logic          call_en = 1'b0;
    logic          ret_en = 1'b0;
    logic [AW-1:0] target_addr = '0;
    logic [AW-1:0] fetch_addr;
    logic [AW-1:0] ret_addr;

    int n_vec = 0;
    int n_bad = 0;

    // bench reference state
    logic [AW-1:0] m_pc;
    logic [AW-1:0] m_mem [SD];
    logic [3:0]    m_sp;

    lfsr_fetch_seq dut (
        .clk(clk), .rst_n(rst_n), .jump_en(jump_en), .call_en(call_en),
        .ret_en(ret_en), .target_addr(target_addr),
        .fetch_addr(fetch_addr), .ret_addr(ret_addr)
    );

    always #10 clk = ~clk;

    function automatic logic [AW-1:0] succ(input logic [AW-1:0] v);
        return {v[8:0], v[9] ^ v[6]};
    endfunction

    function automatic logic [AW-1:0] m_top();
        return m_mem[m_sp - 4'd1];
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 10'h001;
        m_sp = 4'd0;
        for (int i = 0; i < SD; i++) m_mem[i] = '0;
    endtask

    // drive one instruction, advance the model, check at the next negedge
    task automatic step(input logic j, input logic c, input logic r,
                        input logic [AW-1:0] t, input string req);
        logic [AW-1:0] nxt;
        jump_en = j; call_en = c; ret_en = r; target_addr = t;
        if (j) begin
            nxt = t;
        end else if (c) begin
            nxt = t;
            m_mem[m_sp] = succ(m_pc);
            m_sp = m_sp + 4'd1;
        end else if (r) begin
            nxt = m_top();
            m_sp = m_sp - 4'd1;
        end else begin
            nxt = succ(m_pc);
        end
        m_pc = nxt;
        @(posedge clk);
        @(negedge clk);
        check({req, " fetch"}, fetch_addr, m_pc);
        check({req, " ret"}, ret_addr, m_top());
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        jump_en = 0; call_en = 0; ret_en = 0; target_addr = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        model_reset();
        check("R1 reset fetch", fetch_addr, 10'h001);
        check("R1 reset ret", ret_addr, '0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        logic [AW-1:0] t;
        logic [AW-1:0] saved;
        bit zero_seen;
        int first_ret;
        seed_dummy = $urandom(32'd1407);
        model_reset();
        @(negedge clk);
        do_reset();

        // R2 and R3: walk the whole sequence
        zero_seen = 0;
        first_ret = -1;
        for (int k = 1; k <= 1023; k++) begin
            step(0, 0, 0, '0, "R2 seq");
            if (fetch_addr == '0) zero_seen = 1;
            if (fetch_addr == 10'h001 && first_ret < 0) first_ret = k;
        end
        check("R3 never zero", {9'd0, zero_seen}, 10'd0);
        check("R3 period", AW'(first_ret), 10'd1023);

        // R4: jump leaves stack alone
        step(0, 1, 0, 10'h155, "R5 call");
        saved = ret_addr;
        step(1, 0, 0, 10'h2AA, "R4 jump");
        check("R4 stack unchanged", ret_addr, saved);
        // R6: zero-cycle return to saved successor
        step(0, 0, 1, '0, "R6 return");
        check("R6 return target", fetch_addr, saved);

        // R7: priority combinations
        step(1, 1, 1, 10'h0F0, "R7 jump>call>ret");
        step(0, 1, 1, 10'h00F, "R7 call>ret");
        step(1, 0, 1, 10'h111, "R7 jump>ret");
        step(0, 0, 1, '0, "R7 pop after call");

        // R8: overflow wraps after 17 pushes, then underflow
        do_reset();
        for (int k = 0; k < 17; k++) step(0, 1, 0, AW'(10'h010 + k), "R8 push wrap");
        for (int k = 0; k < 18; k++) step(0, 0, 1, '0, "R8 pop wrap");
        // R8: pop at depth zero reads entry 15
        do_reset();
        step(0, 0, 1, '0, "R8 underflow");
        check("R9 top after underflow", ret_addr, m_mem[14]);

        // random mix (R2, R4, R5, R6, R7, R9)
        for (int k = 0; k < 3000; k++) begin
            int sel;
            sel = $urandom_range(0, 9);
            t = AW'($urandom_range(1, 1023));
            case (sel)
                0:       step(1, $urandom_range(0, 1), $urandom_range(0, 1), t, "R4 rnd");
                1, 2:    step(0, 1, $urandom_range(0, 1), t, "R5 rnd");
                3, 4:    step(0, 0, 1, t, "R6 rnd");
                default: step(0, 0, 0, t, "R9 rnd");
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule